// File: doc/BRIEF.md
# Keyed Power-Off and Wake-Up Sequencer

This block sits in the always-on domain and runs on the slow clock. Software cuts power to the main domain by writing a control word that carries an 8-bit password. The block then holds its power-off output high until an enabled wake event is seen, drops the output and records which event caused the wake-up.

There are three wake sources. The first is an external pin, passed through a synchronizer, qualified by a selectable polarity mode and filtered by a programmable debounce count. The other two are request lines from a real-time timer and a real-time clock, and each has its own enable. Software reads the cause from a status register, and a read clears it.

The register port is a simple single-cycle strobe interface. Read data is registered and appears in the cycle after the read strobe.

Top module: `shdn_ctrl`

## Requirements
- R1: After reset the power-off output is low. The mode register (offset 0x4) reads zero and the status register (offset 0x8) reads zero.
- R2: A write to offset 0x0 raises the power-off output on the next clock edge, but only when the write data has 0xA5 in bits 31:24 and bit 0 set.
- R3: A write to offset 0x0 with any other key value, or with bit 0 clear, leaves the output unchanged. A read of offset 0x0 returns zero.
- R4: The mode register holds the pin mode in bits 2:0, the debounce count in bits 7:4, the timer wake enable in bit 16 and the clock wake enable in bit 17. Every other bit reads zero. Its value is kept across power-off and wake-up.
- R5: Pin mode 1 wakes on a high level and pin mode 2 wakes on a low level. Mode 0 and modes 4 to 7 never wake from the pin.
- R6: In pin mode 3, the wake condition is a synchronized pin level that differs from the level sampled when power-off began.
- R7: The pin condition must hold for (count + 1) consecutive clock cycles. Any break in the condition restarts the count.
- R8: The timer request wakes the block only when bit 16 is set, and the clock request only when bit 17 is set.
- R9: Wake sources are evaluated only while the output is high. Events seen while the output is low change neither the output nor the status.
- R10: An accepted wake-up drops the output on the next edge and sets status bit 0 (pin), bit 16 (timer) and/or bit 17 (clock). Events that arrive in the same cycle set all of their matching bits.
- R11: A status read returns the status and clears it. A bit that is set in the same cycle as the read is kept for the next read.
- R12: The pin passes through two flops before qualification. A pin change therefore reaches the qualifier two edges later.
- R13: Read data appears in the cycle after the read strobe and is zero when no read is made. Offsets other than 0x4 and 0x8 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wkup_pin | input | 1 | External wake pin, asynchronous |
| rtt_wake_req | input | 1 | Wake request from the real-time timer |
| rtc_wake_req | input | 1 | Wake request from the real-time clock |
| pwr_off | output | 1 | High while the main domain is powered down |

## Verification
The assertions assume that the timer and clock request lines are already synchronous to the slow clock. They also assume that bus strobes last one cycle and that address and data stay stable within that cycle. The bench drives every input at the falling edge and gives each bus access a single cycle. Only the pin is moved freely, and that includes glitches shorter than the debounce window, since the pin is the only asynchronous input. Mode fields are changed only between power-off episodes, except for the deliberate update made while powered down to show that the register keeps its value.

// File: rtl/shdn_pkg.sv
package shdn_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned DCNT_W  = 4;
  localparam int unsigned PMODE_W = 3;
  localparam logic [7:0]  PWR_KEY = 8'hA5;
  localparam int unsigned KEY_LSB = 24;

  localparam int unsigned OFF_CTRL = 0;
  localparam int unsigned OFF_MODE = 4;
  localparam int unsigned OFF_STAT = 8;

  localparam int unsigned MD_CNT_LSB = 4;
  localparam int unsigned MD_RTT_BIT = 16;
  localparam int unsigned MD_RTC_BIT = 17;

  localparam int unsigned ST_PIN_BIT = 0;
  localparam int unsigned ST_RTT_BIT = 16;
  localparam int unsigned ST_RTC_BIT = 17;

  typedef enum logic [PMODE_W-1:0] {
    PM_OFF = 3'd0,
    PM_HI  = 3'd1,
    PM_LO  = 3'd2,
    PM_CHG = 3'd3
  } pin_mode_e;

  typedef struct packed {
    logic                rtc_en;
    logic                rtt_en;
    logic [DCNT_W-1:0]   dcnt;
    logic [PMODE_W-1:0]  pmode;
  } mode_t;

  function automatic mode_t mode_from_word(input logic [REG_W-1:0] w);
    mode_t m;
    m.rtc_en = w[MD_RTC_BIT];
    m.rtt_en = w[MD_RTT_BIT];
    m.dcnt   = w[MD_CNT_LSB +: DCNT_W];
    m.pmode  = w[PMODE_W-1:0];
    return m;
  endfunction

  function automatic logic [REG_W-1:0] mode_to_word(input mode_t m);
    logic [REG_W-1:0] w;
    w = '0;
    w[MD_RTC_BIT]              = m.rtc_en;
    w[MD_RTT_BIT]              = m.rtt_en;
    w[MD_CNT_LSB +: DCNT_W]    = m.dcnt;
    w[PMODE_W-1:0]             = m.pmode;
    return w;
  endfunction
endpackage

// File: rtl/shdn_sync.sv
module shdn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/shdn_regs.sv
module shdn_regs
  import shdn_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  status_i,
  output logic [REG_W-1:0]  bus_rdata,
  output mode_t             mode_o,
  output logic              off_req_o,
  output logic              stat_rd_o
);
  logic  sel_ctrl, sel_mode, sel_stat;
  mode_t mode_q;
  logic  unused_wbits;

  assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_mode = (bus_addr == ADDR_W'(OFF_MODE));
  assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
  assign unused_wbits = ^bus_wdata;

  always_comb begin
    off_req_o = bus_wr && sel_ctrl
                && (bus_wdata[KEY_LSB +: 8] == PWR_KEY) && bus_wdata[0];
    stat_rd_o = bus_rd && sel_stat;
  end

  always_ff @(posedge clk) begin
    if (rst)                    mode_q <= '0;
    else if (bus_wr && sel_mode) mode_q <= mode_from_word(bus_wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_mode)      bus_rdata <= mode_to_word(mode_q);
      else if (sel_stat) bus_rdata <= status_i;
      else               bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/shdn_pin_qual.sv
module shdn_pin_qual
  import shdn_pkg::*;
#(
  parameter int unsigned CNT_W = DCNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               armed,
  input  logic               enter,
  input  logic               pin_s,
  input  logic [PMODE_W-1:0] pmode,
  input  logic [CNT_W-1:0]   limit,
  output logic               hit
);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic             ref_q;
  logic             cond;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)        ref_q <= 1'b0;
    else if (enter) ref_q <= pin_s;
  end

  always_comb begin
    case (pin_mode_e'(pmode))
      PM_HI:   cond = pin_s;
      PM_LO:   cond = !pin_s;
      PM_CHG:  cond = (pin_s != ref_q);
      default: cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !armed || !cond) run_q <= '0;
    else if (run_q != RUN_MAX)  run_q <= run_q + 1'b1;
  end

  assign hit = armed && cond && (run_q >= limit);
endmodule

// File: rtl/shdn_status.sv
module shdn_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (clr_i ? '0 : q_o) | set_i;
  end
endmodule

// File: rtl/shdn_ctrl.sv
module shdn_ctrl
  import shdn_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wkup_pin,
  input  logic              rtt_wake_req,
  input  logic              rtc_wake_req,
  output logic              pwr_off
);
  mode_t            mode_q;
  logic             off_req, stat_rd;
  logic             shut_q, enter, pin_s, pin_hit, wake;
  logic [REG_W-1:0] status_q, wake_set;

  shdn_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_i(status_q),
    .bus_rdata(bus_rdata), .mode_o(mode_q), .off_req_o(off_req),
    .stat_rd_o(stat_rd)
  );

  shdn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(wkup_pin), .q(pin_s)
  );

  assign enter = !shut_q && off_req;

  shdn_pin_qual #(.CNT_W(DCNT_W)) u_qual (
    .clk(clk), .rst(rst), .armed(shut_q), .enter(enter), .pin_s(pin_s),
    .pmode(mode_q.pmode), .limit(mode_q.dcnt), .hit(pin_hit)
  );

  always_comb begin
    wake_set             = '0;
    wake_set[ST_PIN_BIT] = pin_hit;
    wake_set[ST_RTT_BIT] = shut_q && mode_q.rtt_en && rtt_wake_req;
    wake_set[ST_RTC_BIT] = shut_q && mode_q.rtc_en && rtc_wake_req;
    wake                 = |wake_set;
  end

  shdn_status #(.W(REG_W)) u_stat (
    .clk(clk), .rst(rst), .set_i(wake_set), .clr_i(stat_rd), .q_o(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         shut_q <= 1'b0;
    else if (shut_q) shut_q <= !wake;
    else             shut_q <= off_req;
  end

  assign pwr_off = shut_q;
endmodule

// File: rtl/shdn_ctrl_chk.sv
module shdn_ctrl_chk
  import shdn_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              pwr_off,
  input mode_t             mode_q,
  input logic [31:0]       status_q
);
  logic keyed;
  logic unused_chk;
  assign keyed = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL))
                 && (bus_wdata[31:24] == 8'hA5) && bus_wdata[0];
  assign unused_chk = ^bus_wdata[23:1] ^ mode_q.dcnt[0];

  // R2
  a_r2_keyed_off: assert property (@(posedge clk) disable iff (rst)
    keyed && !pwr_off |=> pwr_off);
  // R3
  a_r3_no_stray_off: assert property (@(posedge clk) disable iff (rst)
    !keyed && !pwr_off |=> !pwr_off);
  a_r3_ctrl_reads_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == ADDR_W'(OFF_CTRL) |=> bus_rdata == 32'h0);
  // R4
  a_r4_mode_unused_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == ADDR_W'(OFF_MODE) |=> (bus_rdata & ~32'h0003_00F7) == 32'h0);
  // R8
  a_r8_no_source_stays_off: assert property (@(posedge clk) disable iff (rst)
    pwr_off && !mode_q.rtt_en && !mode_q.rtc_en && mode_q.pmode == 3'd0 |=> pwr_off);
  // R10
  a_r10_wake_leaves_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_off) |-> status_q != 32'h0);
  // R11
  a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == ADDR_W'(OFF_STAT) && !pwr_off |=> status_q == 32'h0);
endmodule

bind shdn_ctrl shdn_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_off(pwr_off),
  .mode_q(mode_q), .status_q(status_q)
);

// File: tb/test_shdn_ctrl.sv
module test_shdn_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wkup_pin = 1'b0, rtt_wake_req = 1'b0, rtc_wake_req = 1'b0;
  logic        pwr_off;

  always #5 clk = ~clk;

  shdn_ctrl i_shdn_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wkup_pin(wkup_pin),
    .rtt_wake_req(rtt_wake_req), .rtc_wake_req(rtc_wake_req), .pwr_off(pwr_off)
  );

  int    total = 0, bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  int          m_pin1, m_pin2, m_ref, m_run, m_pm, m_cv;
  bit          m_off, m_rtten, m_rtcen;
  logic [31:0] m_stat, m_rdata;

  always @(posedge clk) begin : ref_model
    bit          qual;
    int          streak;
    logic [31:0] hits;
    if (rst) begin
      m_pin1 = 0; m_pin2 = 0; m_ref = 0; m_run = 0; m_pm = 0; m_cv = 0;
      m_off = 0; m_rtten = 0; m_rtcen = 0; m_stat = 0; m_rdata = 0;
    end else begin
      if (m_pm == 1)      qual = (m_pin2 == 1);
      else if (m_pm == 2) qual = (m_pin2 == 0);
      else if (m_pm == 3) qual = (m_pin2 != m_ref);
      else                qual = 0;
      hits = 0;
      streak = 0;
      if (m_off) begin
        streak = qual ? m_run + 1 : 0;
        if (streak > m_cv) hits[0] = 1;
        if (m_rtten && rtt_wake_req) hits[16] = 1;
        if (m_rtcen && rtc_wake_req) hits[17] = 1;
      end
      m_run = streak;
      m_rdata = 0;
      if (bus_rd && bus_addr == 4)
        m_rdata = (32'(m_rtcen) << 17) | (32'(m_rtten) << 16) | (32'(m_cv) << 4) | 32'(m_pm);
      if (bus_rd && bus_addr == 8) begin
        m_rdata = m_stat;
        m_stat = 0;
      end
      m_stat = m_stat | hits;
      if (m_off) begin
        if (hits != 0) m_off = 0;
      end else if (bus_wr && bus_addr == 0 && bus_wdata[31:24] == 8'hA5 && bus_wdata[0]) begin
        m_off = 1;
        m_ref = m_pin2;
      end
      if (bus_wr && bus_addr == 4) begin
        m_pm = int'(bus_wdata[2:0]); m_cv = int'(bus_wdata[7:4]);
        m_rtten = bus_wdata[16]; m_rtcen = bus_wdata[17];
      end
      m_pin2 = m_pin1;
      m_pin1 = int'(wkup_pin);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      total += 2;
      if (pwr_off !== m_off) begin
        bad++;
        $display("FAIL %s pwr_off actual=%0b expected=%0b t=%0t", cur_req, pwr_off, m_off, $time);
      end
      if (bus_rdata !== m_rdata) begin
        bad++;
        $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, bus_rdata, m_rdata, $time);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic power_down();
    wr(4'h0, 32'hA500_0001);
  endtask

  task automatic pulse_rtt();
    @(negedge clk); rtt_wake_req = 1'b1;
    @(negedge clk); rtt_wake_req = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stimulus
    idle(3);
    rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    rd(4'h4); rd(4'h8); idle(2);

    // R3: wrong key, missing command bit, control reads zero
    cur_req = "R3";
    wr(4'h0, 32'hA400_0001); idle(2);
    wr(4'h0, 32'hA5FF_FFFE); idle(2);
    wr(4'h0, 32'h5A00_0001); idle(2);
    rd(4'h0); idle(1);

    // R4: unused bits, field layout
    cur_req = "R4";
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4);
    wr(4'h4, 32'h0001_0000); rd(4'h4);

    // R9: events while powered up are ignored
    cur_req = "R9";
    pulse_rtt(); wkup_pin = 1'b1; idle(4); wkup_pin = 1'b0; idle(3);
    rd(4'h8);

    // R2, R8: keyed power-off, disabled clock request ignored, timer wakes
    cur_req = "R2";
    power_down(); idle(3);
    cur_req = "R8";
    @(negedge clk); rtc_wake_req = 1'b1;
    @(negedge clk); rtc_wake_req = 1'b0;
    idle(3);
    pulse_rtt(); idle(2);
    // R10, R11: status cause then cleared by read
    cur_req = "R10";
    rd(4'h8);
    cur_req = "R11";
    rd(4'h8); idle(2);

    // R5 R12: high level, zero debounce
    cur_req = "R5 R12";
    wr(4'h4, 32'h0000_0001);
    wkup_pin = 1'b0; idle(3);
    power_down(); idle(4);
    wkup_pin = 1'b1; idle(6);
    rd(4'h8); wkup_pin = 1'b0; idle(3);

    // R7: low level with count 3 and a glitch
    cur_req = "R7";
    wr(4'h4, 32'h0000_0032);
    wkup_pin = 1'b1; idle(3);
    power_down(); idle(3);
    wkup_pin = 1'b0; idle(2);
    wkup_pin = 1'b1; idle(4);
    wkup_pin = 1'b0; idle(2);
    wkup_pin = 1'b1; idle(4);
    wkup_pin = 1'b0; idle(10);
    rd(4'h8); idle(2);

    // R6: any change, both directions
    cur_req = "R6";
    wr(4'h4, 32'h0000_0013);
    wkup_pin = 1'b0; idle(3);
    power_down(); idle(4);
    wkup_pin = 1'b1; idle(8);
    rd(4'h8); idle(2);
    power_down(); idle(4);
    wkup_pin = 1'b0; idle(8);
    rd(4'h8); idle(2);

    // R10: both timer sources in one cycle
    cur_req = "R10";
    wr(4'h4, 32'h0003_0000);
    power_down(); idle(2);
    @(negedge clk); rtt_wake_req = 1'b1; rtc_wake_req = 1'b1;
    @(negedge clk); rtt_wake_req = 1'b0; rtc_wake_req = 1'b0;
    rd(4'h8); idle(2);

    // R11: read in the same cycle as a wake event
    cur_req = "R11";
    power_down(); idle(2);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'h8; rtt_wake_req = 1'b1;
    @(negedge clk); bus_rd = 1'b0; rtt_wake_req = 1'b0;
    rd(4'h8); rd(4'h8); idle(2);

    // R5: modes 0 and 4 ignore the pin; R4 mode kept across the episode
    cur_req = "R5";
    wr(4'h4, 32'h0000_0000);
    power_down(); idle(2);
    for (int k = 0; k < 4; k++) begin
      wkup_pin = ~wkup_pin; idle(5);
    end
    wr(4'h4, 32'h0000_0004);
    for (int k = 0; k < 4; k++) begin
      wkup_pin = ~wkup_pin; idle(5);
    end
    cur_req = "R4";
    wr(4'h4, 32'h0001_00A4);
    pulse_rtt(); idle(2);
    rd(4'h4); rd(4'h8);

    // R13: unknown offsets read zero and ignore writes
    cur_req = "R13";
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC); rd(4'h4); idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule